// File: doc/BRIEF.md
# Tiered Register Write-Lock Controller

This block guards the configuration registers of a timer against stray software writes. It watches a simple register write bus, made of a strobe, an address, data and one enable per byte lane. From each write it derives one write enable for every protected field. Each enable is then cleared when the current protection tier forbids a write to that field. The registers themselves sit outside the block. A register updates a field only when its enable from this block is high.

The protection tier is a 2-bit value. It arms on the first write after reset to the protection register, which holds it, and no later write can change it until the next reset. The tiers nest. Tier 1 freezes the dead-time code, the break controls and the idle levels. Tier 2 adds the two off-state selects and the polarity bits of output channels. Tier 3 adds the compare-mode and preload bits of output channels. A separate per-channel input marks which channels are outputs. Channels used as inputs keep their polarity, mode and preload fields writable at every tier.

Top module: `tiered_wlock`

## Requirements
- R1: After reset the tier output reads 00, and at tier 00 every field write enable follows the decoded write with nothing blocked.
- R2: The first write to the protection register (address A_PROT) after reset loads the tier from data bits [9:8] if byte lane 1 is enabled, or 00 if it is not. Every later write leaves the tier unchanged.
- R3: A first write that loads tier 00 still uses up the one-shot load, so a later write of 11 leaves the tier at 00.
- R4: At any tier other than 00, the enables for the dead-time code, the four break controls and all idle-level bits stay low.
- R5: At tier 10 or above, both off-state select enables stay low. The polarity enables (bits 2c and 2c+1 of the polarity register for channel c) stay low for channels whose i_ch_is_out bit is 1 and pass for the other channels.
- R6: At tier 11, the compare-mode and preload enables stay low for output channels and pass for input channels.
- R7: A blocked field does not block other fields of the same write that are allowed at the current tier.
- R8: A field enable is high only when i_wr_en is high, the address matches the field's register, and the byte lane that holds the field is enabled. In the protection register the dead-time code is bits [7:0] (lane 0). The idle-state select, run-state select, break enable, break polarity, break bidirectional and automatic-output-enable bits are bits 10 to 15, in that order (lane 1). Idle and polarity bits of channel c are bits 2c (main) and 2c+1 (complementary). Channel c's mode is bits [4c+2:4c] and its preload is bit 4c+3.
- R9: Each write is gated by the tier in force before it, so the write that arms the tier still updates the other fields it carries.
- R10: A reset clears the tier to 00 and re-arms the one-shot load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_wr_en | input | 1 | Write strobe |
| i_wr_addr | input | AW | Register address |
| i_wr_data | input | DW | Write data |
| i_wr_be | input | DW/8 | Byte lane enables |
| i_ch_is_out | input | NCH | Per-channel output configuration (1 = output) |
| o_lock_level | output | 2 | Current protection tier |
| o_we_dtime | output | 1 | Dead-time code write enable |
| o_we_brk | output | 4 | Break enable, break polarity, break bidirectional, auto-output-enable write enables |
| o_we_offsel | output | 2 | Idle-state and run-state select write enables |
| o_we_idle | output | 2*NCH | Idle-level write enables |
| o_we_pol | output | 2*NCH | Polarity write enables |
| o_we_ocmode | output | NCH | Compare-mode write enables |
| o_we_preload | output | NCH | Preload write enables |

## Verification
The bench builds the block with its defaults: four channels, a 32-bit data bus with four byte lanes, and a 4-bit address. Four channels let a single channel mask mix output and input channels. That shows the per-channel polarity and mode gating as alternating bit patterns, not as all-or-nothing results. A 32-bit bus places channel pairs in separate lanes, so partial lane enables must produce partial enable vectors. Reset is applied between scenarios, which brings each tier within reach once and lets the bench exercise the re-arming of the one-shot load.

// File: rtl/wlk_pkg.sv
// Package for the tiered write-lock controller.
// Holds the tier encoding and the bit positions inside the protection register.
// Assumes: DW >= 16. The tier field sits in byte lane 1.
package wlk_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN  = 2'b00,
        LVL_BASIC = 2'b01,
        LVL_MID   = 2'b10,
        LVL_FULL  = 2'b11
    } lock_lvl_e;

    localparam int DT_LSB    = 0;
    localparam int DT_W      = 8;
    localparam int LOCK_LSB  = 8;
    localparam int OFF_LSB   = 10;   // idle-state select, then run-state select
    localparam int BRK_LSB   = 12;   // enable, polarity, bidirectional, auto-output-enable
    localparam int BRK_W     = 4;
    localparam int DT_LANE   = DT_LSB / 8;
    localparam int LOCK_LANE = LOCK_LSB / 8;
    localparam int OFF_LANE  = OFF_LSB / 8;
    localparam int BRK_LANE  = BRK_LSB / 8;

endpackage

// File: rtl/wlk_lock_reg.sv
// One-shot tier register.
// Loads the tier on the first access to the protection register after reset.
// The tier is taken from the data when the lane holding it is enabled, else 00.
// Assumes: prot_hit is a single-cycle qualified write indication.
module wlk_lock_reg
    import wlk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      prot_hit,
    input  logic      lane_en,
    input  logic [1:0] lvl_wdata,
    output lock_lvl_e level,
    output logic      used
);

    // Capture the tier once and then hold it until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= LVL_OPEN;
            used  <= 1'b0;
        end else if (prot_hit && !used) begin
            used  <= 1'b1;
            level <= lane_en ? lock_lvl_e'(lvl_wdata) : LVL_OPEN;
        end
    end

endmodule

// File: rtl/wlk_decode.sv
// Address and byte-lane decode.
// Turns one bus write into raw per-field enables, before any tier gating.
// Assumes: DW >= 16, 4*NCH <= DW, and the four addresses are distinct.
module wlk_decode
    import wlk_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int A_PROT = 0,
    parameter int A_IDLE = 1,
    parameter int A_POL  = 2,
    parameter int A_MODE = 3,
    localparam int NBE   = DW / 8
) (
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NBE-1:0]   wr_be,
    output logic             hit_prot,
    output logic             raw_dt,
    output logic [BRK_W-1:0] raw_brk,
    output logic [1:0]       raw_off,
    output logic [2*NCH-1:0] raw_idle,
    output logic [2*NCH-1:0] raw_pol,
    output logic [NCH-1:0]   raw_mode,
    output logic [NCH-1:0]   raw_pre
);

    logic hit_idle, hit_pol, hit_mode;

    // Qualify the address with the write strobe for each register.
    always_comb begin
        hit_prot = wr_en && (wr_addr == AW'(A_PROT));
        hit_idle = wr_en && (wr_addr == AW'(A_IDLE));
        hit_pol  = wr_en && (wr_addr == AW'(A_POL));
        hit_mode = wr_en && (wr_addr == AW'(A_MODE));
    end

    // Fields inside the protection register.
    always_comb begin
        raw_dt  = hit_prot && wr_be[DT_LANE];
        raw_brk = {BRK_W{hit_prot && wr_be[BRK_LANE]}};
        raw_off = {2{hit_prot && wr_be[OFF_LANE]}};
    end

    // Two bits per channel: main and complementary.
    for (genvar i = 0; i < 2*NCH; i++) begin : g_pair
        assign raw_idle[i] = hit_idle && wr_be[i/8];
        assign raw_pol[i]  = hit_pol  && wr_be[i/8];
    end

    // One nibble per channel: mode in the low three bits, preload on top.
    for (genvar c = 0; c < NCH; c++) begin : g_mode
        assign raw_mode[c] = hit_mode && wr_be[(4*c)/8];
        assign raw_pre[c]  = hit_mode && wr_be[(4*c+3)/8];
    end

endmodule

// File: rtl/wlk_gate.sv
// Tier policy.
// Clears raw field enables according to the current tier and the per-channel
// output configuration.
// Assumes: level is the registered tier, i.e. the tier in force before this write.
module wlk_gate
    import wlk_pkg::*;
#(
    parameter int NCH = 4
) (
    input  lock_lvl_e        level,
    input  logic [NCH-1:0]   ch_is_out,
    input  logic             raw_dt,
    input  logic [BRK_W-1:0] raw_brk,
    input  logic [1:0]       raw_off,
    input  logic [2*NCH-1:0] raw_idle,
    input  logic [2*NCH-1:0] raw_pol,
    input  logic [NCH-1:0]   raw_mode,
    input  logic [NCH-1:0]   raw_pre,
    output logic             we_dt,
    output logic [BRK_W-1:0] we_brk,
    output logic [1:0]       we_off,
    output logic [2*NCH-1:0] we_idle,
    output logic [2*NCH-1:0] we_pol,
    output logic [NCH-1:0]   we_mode,
    output logic [NCH-1:0]   we_pre
);

    logic tier1, tier2, tier3;

    // Nested tier flags.
    always_comb begin
        tier1 = (level != LVL_OPEN);
        tier2 = (level == LVL_MID) || (level == LVL_FULL);
        tier3 = (level == LVL_FULL);
    end

    // Fields frozen regardless of channel direction.
    always_comb begin
        we_dt   = raw_dt && !tier1;
        we_brk  = raw_brk  & {BRK_W{!tier1}};
        we_idle = raw_idle & {(2*NCH){!tier1}};
        we_off  = raw_off  & {2{!tier2}};
    end

    // Fields frozen only for channels configured as outputs.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign we_pol[2*c]   = raw_pol[2*c]   && !(tier2 && ch_is_out[c]);
        assign we_pol[2*c+1] = raw_pol[2*c+1] && !(tier2 && ch_is_out[c]);
        assign we_mode[c]    = raw_mode[c]    && !(tier3 && ch_is_out[c]);
        assign we_pre[c]     = raw_pre[c]     && !(tier3 && ch_is_out[c]);
    end

endmodule

// File: rtl/tiered_wlock.sv
// Tiered register write-lock controller, top level.
// Decodes bus writes into per-field enables and masks them by the one-shot tier.
// Assumes: write enables are consumed by the registers in the same cycle.
module tiered_wlock
    import wlk_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DW     = 32,
    parameter int AW     = 4,
    parameter int A_PROT = 0,
    parameter int A_IDLE = 1,
    parameter int A_POL  = 2,
    parameter int A_MODE = 3,
    localparam int NBE   = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_wr_en,
    input  logic [AW-1:0]    i_wr_addr,
    input  logic [DW-1:0]    i_wr_data,
    input  logic [NBE-1:0]   i_wr_be,
    input  logic [NCH-1:0]   i_ch_is_out,
    output logic [1:0]       o_lock_level,
    output logic             o_we_dtime,
    output logic [3:0]       o_we_brk,
    output logic [1:0]       o_we_offsel,
    output logic [2*NCH-1:0] o_we_idle,
    output logic [2*NCH-1:0] o_we_pol,
    output logic [NCH-1:0]   o_we_ocmode,
    output logic [NCH-1:0]   o_we_preload
);

    lock_lvl_e        level;
    logic             lock_used;
    logic             hit_prot;
    logic             raw_dt;
    logic [BRK_W-1:0] raw_brk;
    logic [1:0]       raw_off;
    logic [2*NCH-1:0] raw_idle, raw_pol;
    logic [NCH-1:0]   raw_mode, raw_pre;
    logic             unused_data;

    // Only the tier bits of the data bus matter to this block.
    assign unused_data = ^{i_wr_data[DW-1:LOCK_LSB+2], i_wr_data[LOCK_LSB-1:0]};

    wlk_decode #(
        .NCH(NCH), .DW(DW), .AW(AW),
        .A_PROT(A_PROT), .A_IDLE(A_IDLE), .A_POL(A_POL), .A_MODE(A_MODE)
    ) u_dec (
        .wr_en    (i_wr_en),
        .wr_addr  (i_wr_addr),
        .wr_be    (i_wr_be),
        .hit_prot (hit_prot),
        .raw_dt   (raw_dt),
        .raw_brk  (raw_brk),
        .raw_off  (raw_off),
        .raw_idle (raw_idle),
        .raw_pol  (raw_pol),
        .raw_mode (raw_mode),
        .raw_pre  (raw_pre)
    );

    wlk_lock_reg u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_hit  (hit_prot),
        .lane_en   (i_wr_be[LOCK_LANE]),
        .lvl_wdata (i_wr_data[LOCK_LSB+1:LOCK_LSB]),
        .level     (level),
        .used      (lock_used)
    );

    wlk_gate #(.NCH(NCH)) u_gate (
        .level     (level),
        .ch_is_out (i_ch_is_out),
        .raw_dt    (raw_dt),
        .raw_brk   (raw_brk),
        .raw_off   (raw_off),
        .raw_idle  (raw_idle),
        .raw_pol   (raw_pol),
        .raw_mode  (raw_mode),
        .raw_pre   (raw_pre),
        .we_dt     (o_we_dtime),
        .we_brk    (o_we_brk),
        .we_off    (o_we_offsel),
        .we_idle   (o_we_idle),
        .we_pol    (o_we_pol),
        .we_mode   (o_we_ocmode),
        .we_pre    (o_we_preload)
    );

    // Expose the tier as a plain vector.
    assign o_lock_level = level;

endmodule

// File: rtl/tiered_wlock_chk.sv
// Assertion checker for tiered_wlock, attached through bind.
// Assumes: it observes the top-level ports plus the one-shot flag.
module tiered_wlock_chk #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             lock_used,
    input logic [NCH-1:0]   ch_is_out,
    input logic [1:0]       lock_level,
    input logic             we_dtime,
    input logic [3:0]       we_brk,
    input logic [1:0]       we_offsel,
    input logic [2*NCH-1:0] we_idle,
    input logic [2*NCH-1:0] we_pol,
    input logic [NCH-1:0]   we_ocmode,
    input logic [NCH-1:0]   we_preload
);

    logic [2*NCH-1:0] out_pairs;

    // Widen the channel mask to one bit per polarity field.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            out_pairs[2*c]   = ch_is_out[c];
            out_pairs[2*c+1] = ch_is_out[c];
        end
    end

    p_tier_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_used |=> $stable(lock_level));

    p_used_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_used |=> lock_used);

    p_basic_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level != 2'b00) |-> (!we_dtime && we_brk == 4'b0 && we_idle == '0));

    p_offsel_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_level[1] |-> (we_offsel == 2'b00));

    p_pol_out_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_level[1] |-> ((we_pol & out_pairs) == '0));

    p_mode_out_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_level == 2'b11) |-> ((we_ocmode & ch_is_out) == '0 && (we_preload & ch_is_out) == '0));

    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> ($countones({we_dtime, we_brk, we_offsel, we_idle, we_pol, we_ocmode, we_preload}) == 0));

endmodule

bind tiered_wlock tiered_wlock_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (i_wr_en),
    .lock_used  (lock_used),
    .ch_is_out  (i_ch_is_out),
    .lock_level (o_lock_level),
    .we_dtime   (o_we_dtime),
    .we_brk     (o_we_brk),
    .we_offsel  (o_we_offsel),
    .we_idle    (o_we_idle),
    .we_pol     (o_we_pol),
    .we_ocmode  (o_we_ocmode),
    .we_preload (o_we_preload)
);

// File: tb/tiered_wlock_tb_top.sv
// Directed bench for tiered_wlock: one task per scenario.
module tiered_wlock_tb_top;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int AW  = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [DW-1:0]  wr_data = '0;
    logic [3:0]     wr_be = '0;
    logic [NCH-1:0] ch_out = 4'b0101;
    logic [1:0]     lvl;
    logic           we_dt;
    logic [3:0]     we_brk;
    logic [1:0]     we_off;
    logic [7:0]     we_idle, we_pol;
    logic [3:0]     we_mode, we_pre;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tiered_wlock dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .i_wr_en      (wr_en),
        .i_wr_addr    (wr_addr),
        .i_wr_data    (wr_data),
        .i_wr_be      (wr_be),
        .i_ch_is_out  (ch_out),
        .o_lock_level (lvl),
        .o_we_dtime   (we_dt),
        .o_we_brk     (we_brk),
        .o_we_offsel  (we_off),
        .o_we_idle    (we_idle),
        .o_we_pol     (we_pol),
        .o_we_ocmode  (we_mode),
        .o_we_preload (we_pre)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reset for one edge; returns at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive a write at the current falling edge and let outputs settle.
    task automatic drive(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        #1;
    endtask

    // Let the write take effect and release the bus at the next falling edge.
    task automatic commit();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
        #1;
    endtask

    task automatic t_reset_open();
        do_reset();
        #1;
        check("R1", "tier after reset", 32'(lvl), 32'h0);
        check("R8", "idle bus enables", 32'({we_dt, we_brk, we_off, we_idle, we_pol, we_mode, we_pre}), 32'h0);
        drive(4'd1, 32'hFFFF, 4'hF);
        check("R1", "idle write open", 32'(we_idle), 32'hFF);
        commit();
        drive(4'd2, 32'hFFFF, 4'hF);
        check("R1", "polarity write open", 32'(we_pol), 32'hFF);
        commit();
        drive(4'd3, 32'hFFFF, 4'hF);
        check("R1", "mode write open", 32'({we_mode, we_pre}), 32'hFF);
        commit();
    endtask

    task automatic t_lanes();
        drive(4'd3, 32'hFFFF, 4'b0001);
        check("R8", "mode lane0 only", 32'(we_mode), 32'h3);
        commit();
        drive(4'd3, 32'hFFFF, 4'b0010);
        check("R8", "preload lane1 only", 32'(we_pre), 32'hC);
        commit();
        drive(4'd1, 32'hFFFF, 4'b0010);
        check("R8", "idle lane1 only", 32'(we_idle), 32'h0);
        commit();
        drive(4'd7, 32'hFFFF, 4'hF);
        check("R8", "unmapped address", 32'({we_dt, we_brk, we_off, we_idle, we_pol, we_mode, we_pre}), 32'h0);
        commit();
    endtask

    task automatic t_arm_basic();
        drive(4'd0, 32'h0000_0155, 4'b0011);
        check("R9", "arming write keeps dead-time", 32'(we_dt), 32'h1);
        check("R9", "arming write keeps break", 32'(we_brk), 32'hF);
        commit();
        check("R2", "tier loaded", 32'(lvl), 32'h1);
        drive(4'd0, 32'h0000_03AA, 4'b0011);
        check("R4", "dead-time blocked", 32'(we_dt), 32'h0);
        check("R4", "break blocked", 32'(we_brk), 32'h0);
        check("R7", "off-state passes in same write", 32'(we_off), 32'h3);
        commit();
        check("R2", "tier frozen after second write", 32'(lvl), 32'h1);
        drive(4'd1, 32'hFFFF, 4'hF);
        check("R4", "idle blocked", 32'(we_idle), 32'h0);
        commit();
        drive(4'd2, 32'hFFFF, 4'hF);
        check("R4", "polarity open at tier 1", 32'(we_pol), 32'hFF);
        commit();
    endtask

    task automatic t_mid();
        do_reset();
        check("R10", "tier cleared", 32'(lvl), 32'h0);
        drive(4'd0, 32'h0000_0200, 4'b0010);
        commit();
        check("R10", "re-armed load", 32'(lvl), 32'h2);
        drive(4'd2, 32'hFFFF, 4'hF);
        check("R5", "polarity of output channels blocked", 32'(we_pol), 32'hCC);
        commit();
        drive(4'd0, 32'h0, 4'b0010);
        check("R5", "off-state blocked", 32'(we_off), 32'h0);
        commit();
        drive(4'd3, 32'hFFFF, 4'hF);
        check("R6", "mode open at tier 2", 32'(we_mode), 32'hF);
        commit();
    endtask

    task automatic t_full();
        do_reset();
        drive(4'd0, 32'h0000_0300, 4'b0010);
        commit();
        check("R2", "tier 3 loaded", 32'(lvl), 32'h3);
        drive(4'd3, 32'hFFFF, 4'hF);
        check("R6", "mode of output channels blocked", 32'(we_mode), 32'hA);
        check("R6", "preload of output channels blocked", 32'(we_pre), 32'hA);
        commit();
        ch_out = 4'b0000;
        drive(4'd3, 32'hFFFF, 4'hF);
        check("R6", "all-input channels pass mode", 32'(we_mode), 32'hF);
        commit();
        drive(4'd2, 32'hFFFF, 4'hF);
        check("R5", "all-input channels pass polarity", 32'(we_pol), 32'hFF);
        commit();
        ch_out = 4'b0101;
    endtask

    task automatic t_zero_oneshot();
        do_reset();
        drive(4'd0, 32'h0000_0000, 4'b0011);
        commit();
        check("R3", "tier zero after write of 00", 32'(lvl), 32'h0);
        drive(4'd0, 32'h0000_0311, 4'b0011);
        check("R3", "dead-time still open", 32'(we_dt), 32'h1);
        commit();
        check("R3", "second write cannot arm", 32'(lvl), 32'h0);
        do_reset();
        drive(4'd0, 32'h0000_0300, 4'b0001);
        commit();
        check("R2", "lane 1 disabled loads 00", 32'(lvl), 32'h0);
        drive(4'd0, 32'h0000_0300, 4'b0010);
        commit();
        check("R2", "lane-less write used the load", 32'(lvl), 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset_open();
        t_lanes();
        t_arm_basic();
        t_mid();
        t_full();
        t_zero_oneshot();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule